// File: doc/BRIEF.md
# Dual-Path Maskable Interrupt Aggregator

This block merges level-sensitive interrupt requests from 24 peripheral lines and one software-controlled request into two processor request outputs. One output is the normal request, `irq_o`. The other is the fast request, `fiq_o`. The two outputs share one bit map of sources. Each output has its own enable mask, so any source can be sent to the normal path, the fast path, both, or neither.

The block does not encode priority and does not produce a vector. A handler reads the masked status word of its path and decides in software which source to serve. Every pending enabled source stays visible at the same time.

The peripheral lines pass through a two-flop synchronizer before they reach the raw signal word. Both request outputs come from flops, so they do not glitch.

Software reaches the block through a simple register bus with a byte address. Reads are combinational and writes take effect on the clock edge. The register map is as follows:

| Offset | Register |
|---|---|
| `0x000` | normal-path masked status (read-only) |
| `0x004` | raw signal word (read-only) |
| `0x008` | normal-path enable set (write one to set; reads return the mask) |
| `0x00C` | normal-path enable clear (write one to clear; reads return the mask) |
| `0x010` | software request, bit 1 |
| `0x100` to `0x10C` | the same four registers for the fast path |

Top module: `intr_aggr`

## Requirements
- R1: After a synchronous reset, every register reads `0x00000000`, and `irq_o` and `fiq_o` are 0.
- R2: Raw word bit n (n = 2..25) equals `periph_req[n-2]`, delayed by two clock edges. The bit clears when the line drops. A write to a raw word offset (`0x004` or `0x104`) changes nothing.
- R3: Each bit n (1..25) of a path's masked status equals raw bit n AND that path's enable bit n.
- R4: `irq_o` is the OR of the normal-path masked status word, registered one clock edge later.
- R5: Bit 0 of the fast-path status word and bit 0 of the fast-path raw word read 1 exactly when any fast status bit in 1..25 is set. `fiq_o` is that summary, registered one clock edge later. Bit 0 of every normal-path register reads 0.
- R6: A write to `+0x008` sets the enable bits where the written data is 1. A write to `+0x00C` clears the enable bits where the written data is 1. Both offsets read back the current mask. Enable bits 0 and 26..31 always read 0.
- R7: Bit 1 of offset `0x010` holds the software request. A write stores data bit 1, so the same register both sets and clears it. The stored value feeds raw bit 1 on both paths one clock edge after the write.
- R8: The block applies no priority. When several enabled sources are active, all of their status bits read 1 at once.
- R9: Each path's mask is independent. Writing one path's enable registers never changes the other path's mask or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_req | input | 24 | Peripheral request levels; bit k maps to source bit k+2 |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Registered normal request to the processor |
| fiq_o | output | 1 | Registered fast request to the processor |

## Verification
Two events can land in the same cycle:
- a peripheral line changing its level;
- a software write to an enable register or to the software request bit.

Either one alone can flip a status bit. The bench provokes the overlap by driving a new request level in the same bus cycle as an enable-clear write. It then checks that the settled status and outputs equal the AND of the final raw levels and the final mask. No transient pulse may survive on the registered output.

// File: rtl/intr_aggr_pkg.sv
package intr_aggr_pkg;

    localparam int DW        = 32;
    localparam int SUM_BIT   = 0;
    localparam int SOFT_BIT  = 1;
    localparam int PER_LO    = 2;
    localparam int SRC_HI    = 25;
    localparam int NPERIPH   = SRC_HI - PER_LO + 1;
    localparam int ADDR_W    = 10;

    typedef enum logic [2:0] {
        K_STAT, K_RAW, K_ESET, K_ECLR, K_SOFT, K_NONE
    } reg_kind_e;

    typedef struct packed {
        logic      fast;
        reg_kind_e kind;
    } reg_sel_t;

    function automatic logic [DW-1:0] src_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int i = SOFT_BIT; i <= SRC_HI; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic reg_sel_t decode(logic [ADDR_W-1:0] a);
        reg_sel_t r;
        r.fast = a[8];
        r.kind = K_NONE;
        if (!a[9]) begin
            case (a[7:0])
                8'h00:   r.kind = K_STAT;
                8'h04:   r.kind = K_RAW;
                8'h08:   r.kind = K_ESET;
                8'h0C:   r.kind = K_ECLR;
                8'h10:   r.kind = a[8] ? K_NONE : K_SOFT;
                default: r.kind = K_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/intr_src_sync.sv
module intr_src_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/intr_mask_path.sv
module intr_mask_path
    import intr_aggr_pkg::*;
#(
    parameter bit SUMMARY = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] en_o,
    output logic [DW-1:0] st_o,
    output logic          req_o
);
    localparam logic [DW-1:0] VALID = src_mask();

    logic [DW-1:0] en;
    logic [DW-1:0] masked;

    always_ff @(posedge clk) begin
        if (rst)         en <= '0;
        else if (set_we) en <= en | (wdata & VALID);
        else if (clr_we) en <= en & ~wdata;
    end

    assign masked = raw & en & VALID;

    generate
        if (SUMMARY) begin : g_sum
            always_comb begin
                st_o          = masked;
                st_o[SUM_BIT] = |masked;
            end
        end else begin : g_plain
            assign st_o = masked;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) req_o <= 1'b0;
        else     req_o <= |masked;
    end

    assign en_o = en;
endmodule

// File: rtl/intr_aggr.sv
module intr_aggr
    import intr_aggr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPERIPH-1:0] periph_req,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    reg_sel_t         sel;
    logic             wr_en;
    logic             soft_q;
    logic [NPERIPH-1:0] per_sync;
    logic [DW-1:0]    raw_vec;
    logic [DW-1:0]    irq_en, fiq_en, irq_st, fiq_st;

    assign sel   = decode(bus_addr);
    assign wr_en = bus_sel & bus_wr;

    intr_src_sync #(.W(NPERIPH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(periph_req), .q(per_sync)
    );

    always_ff @(posedge clk) begin
        if (rst)                            soft_q <= 1'b0;
        else if (wr_en && sel.kind == K_SOFT) soft_q <= bus_wdata[SOFT_BIT];
    end

    always_comb begin
        raw_vec                   = '0;
        raw_vec[SRC_HI:PER_LO]    = per_sync;
        raw_vec[SOFT_BIT]         = soft_q;
    end

    intr_mask_path #(.SUMMARY(1'b0)) u_irq (
        .clk(clk), .rst(rst),
        .set_we(wr_en && !sel.fast && sel.kind == K_ESET),
        .clr_we(wr_en && !sel.fast && sel.kind == K_ECLR),
        .wdata(bus_wdata), .raw(raw_vec),
        .en_o(irq_en), .st_o(irq_st), .req_o(irq_o)
    );

    intr_mask_path #(.SUMMARY(1'b1)) u_fiq (
        .clk(clk), .rst(rst),
        .set_we(wr_en && sel.fast && sel.kind == K_ESET),
        .clr_we(wr_en && sel.fast && sel.kind == K_ECLR),
        .wdata(bus_wdata), .raw(raw_vec),
        .en_o(fiq_en), .st_o(fiq_st), .req_o(fiq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            K_STAT: bus_rdata = sel.fast ? fiq_st : irq_st;
            K_RAW: begin
                bus_rdata = raw_vec;
                if (sel.fast) bus_rdata[SUM_BIT] = fiq_st[SUM_BIT];
            end
            K_ESET, K_ECLR: bus_rdata = sel.fast ? fiq_en : irq_en;
            K_SOFT: bus_rdata[SOFT_BIT] = soft_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intr_aggr_chk.sv
module intr_aggr_chk
    import intr_aggr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NPERIPH-1:0] periph_req,
    input logic [DW-1:0]      raw_vec,
    input logic [DW-1:0]      irq_en,
    input logic [DW-1:0]      fiq_en,
    input logic [DW-1:0]      irq_st,
    input logic [DW-1:0]      fiq_st,
    input logic               irq_o,
    input logic               fiq_o
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2: raw peripheral bits trail the request lines by two edges
    a_r2_raw_follows: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (raw_vec[SRC_HI:PER_LO] == $past(periph_req, 2)));

    // R3: status never shows a source whose raw bit is clear
    a_r3_status_subset: assert property (@(posedge clk) disable iff (rst)
        ((irq_st & ~raw_vec) == '0) && ((fiq_st[DW-1:1] & ~raw_vec[DW-1:1]) == '0));

    // R4: normal request output is the registered status OR
    a_r4_irq_out: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1) |-> (irq_o == $past(|irq_st)));

    // R5: fast summary bit and output
    a_r5_fiq_summary: assert property (@(posedge clk) disable iff (rst)
        fiq_st[SUM_BIT] == (|fiq_st[SRC_HI:SOFT_BIT]));
    a_r5_fiq_out: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1) |-> (fiq_o == $past(|fiq_st[SRC_HI:SOFT_BIT])));

    // R6: unused enable bits stay zero
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (irq_en[DW-1:SRC_HI+1] == '0) && (fiq_en[DW-1:SRC_HI+1] == '0)
        && !irq_en[SUM_BIT] && !fiq_en[SUM_BIT]);
endmodule

bind intr_aggr intr_aggr_chk u_chk (
    .clk(clk), .rst(rst), .periph_req(periph_req), .raw_vec(raw_vec),
    .irq_en(irq_en), .fiq_en(fiq_en), .irq_st(irq_st), .fiq_st(fiq_st),
    .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/intr_aggr_bench.sv
`timescale 1ns/1ps
module intr_aggr_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] periph_req = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    localparam int NV = 6;
    localparam logic [31:0] T_REQ [NV] = '{32'h0000_0004, 32'h03FF_FFFC, 32'h0001_0100,
                                           32'h0000_0F00, 32'h0000_0000, 32'h00A0_0004};
    localparam logic [31:0] T_IEN [NV] = '{32'h0000_0004, 32'h03FF_FFFE, 32'h0000_0100,
                                           32'h0000_0000, 32'hFFFF_FFFF, 32'h0080_0000};
    localparam logic [31:0] T_FEN [NV] = '{32'h0000_0000, 32'h0200_0000, 32'h0001_0000,
                                           32'h0000_0000, 32'hFFFF_FFFF, 32'h0020_0004};
    localparam logic [31:0] VALID = 32'h03FF_FFFE;

    intr_aggr u_intr_aggr (
        .clk(clk), .rst(rst), .periph_req(periph_req), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #2 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] fsum(logic [31:0] st);
        return st | {31'b0, |st};
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, ei, ef, raw;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        foreach (T_REQ[k]) begin end
        rd(10'h000, d); check("R1 irq status", d, 0);
        rd(10'h004, d); check("R1 raw", d, 0);
        rd(10'h108, d); check("R1 fiq enable", d, 0);
        rd(10'h010, d); check("R1 soft", d, 0);
        check("R1 outputs", {30'b0, irq_o, fiq_o}, 0);

        // table walk: R3 R4 R5 R8
        for (int i = 0; i < NV; i++) begin
            wr(10'h00C, 32'hFFFF_FFFF);
            wr(10'h10C, 32'hFFFF_FFFF);
            wr(10'h008, T_IEN[i]);
            wr(10'h108, T_FEN[i]);
            periph_req = T_REQ[i][25:2];
            repeat (3) @(negedge clk);
            raw = T_REQ[i] & 32'h03FF_FFFC;
            ei  = raw & T_IEN[i] & VALID;
            ef  = fsum(raw & T_FEN[i] & VALID);
            rd(10'h004, d); check("R2 raw word", d, raw);
            rd(10'h000, d); check("R3 R8 irq status", d, ei);
            rd(10'h100, d); check("R5 R8 fiq status", d, ef);
            rd(10'h104, d); check("R5 fiq raw summary", d, raw | {31'b0, ef[0]});
            check("R4 irq_o", {31'b0, irq_o}, {31'b0, |ei});
            check("R5 fiq_o", {31'b0, fiq_o}, {31'b0, ef[0]});
        end

        // R2 raw drops with the line, write to raw ignored
        wr(10'h00C, 32'hFFFF_FFFF); wr(10'h10C, 32'hFFFF_FFFF);
        periph_req = 24'h000001;
        repeat (3) @(negedge clk);
        wr(10'h004, 32'hFFFF_FFFF);
        wr(10'h104, 32'hFFFF_FFFF);
        rd(10'h004, d); check("R2 raw write ignored", d, 32'h4);
        periph_req = '0;
        @(negedge clk);
        rd(10'h004, d); check("R2 one edge not yet cleared", d, 32'h4);
        @(negedge clk);
        rd(10'h004, d); check("R2 cleared after two edges", d, 0);

        // R6 set/clear and reserved bits; R9 independence
        wr(10'h008, 32'hFFFF_FFFF);
        rd(10'h008, d); check("R6 set readback", d, VALID);
        wr(10'h00C, 32'h0000_F000);
        rd(10'h00C, d); check("R6 clear readback", d, VALID & ~32'h0000_F000);
        rd(10'h108, d); check("R9 fiq mask untouched", d, 0);

        // R7 software request feeds both raw words
        wr(10'h108, 32'h2);
        wr(10'h010, 32'h2);
        rd(10'h004, d); check("R7 soft in raw", d, 32'h2);
        rd(10'h010, d); check("R7 soft readback", d, 32'h2);
        @(negedge clk);
        check("R7 irq_o from soft", {31'b0, irq_o}, 1);
        check("R7 fiq_o from soft", {31'b0, fiq_o}, 1);
        rd(10'h100, d); check("R7 fiq status soft", d, 32'h3);
        wr(10'h010, 32'h0);
        @(negedge clk);
        check("R7 soft cleared", {30'b0, irq_o, fiq_o}, 0);

        // R3 R4 concurrency: line rises in the cycle its enable is cleared
        wr(10'h008, 32'h0000_0010);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'h00C; bus_wdata = 32'hFFFF_FFFF;
        periph_req = 24'h000004;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rd(10'h000, d); check("R3 same-cycle clear status", d, 0);
        check("R4 same-cycle clear irq_o", {31'b0, irq_o}, 0);
        periph_req = '0;

        // R1 reset again clears masks
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        rd(10'h008, d); check("R1 mask after reset", d, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule